// File: doc/BRIEF.md
# Row Write Latch with Timed Commit

This block collects the data bytes of one write transaction aimed at a 256 x 8 nonvolatile array and stores them into that array during a self-timed write cycle. A protocol engine in front of it decodes the serial bus. The engine first supplies a start address. It then strobes in data bytes, pulses a bit marker whenever the bus clocks any further bit, and pulses a stop marker when a stop condition appears. The array itself is modelled as on-chip registers. It powers up with every byte at FFh and has a combinational read port for the bus side.

All bytes of one transaction land in one 16-byte row. The row is picked by the upper four address bits. Only the low four bits advance, so a long burst wraps around and overwrites earlier bytes in the same row. A per-byte valid mask tracks which row slots were loaded. The write cycle starts only when the stop marker arrives directly after a data byte, with no bit marker in between. While the cycle runs, `busy_o` stays high for `BUSY_CYCLES` clocks and every strobe is ignored. The loaded slots reach the array on the clock edge at which `busy_o` falls.

Top module: `row_commit_top`

## Requirements
- R1: Out of reset `busy_o` is 0, and every one of the 256 addresses reads FFh on `rd_data_o`.
- R2: `addr_set_i` selects the row from `addr_i[7:4]` and the slot from `addr_i[3:0]`, and drops any bytes already loaded. Each `load_i` places `data_i` in the current slot. On commit, only the loaded slots of that row change in the array; all other bytes keep their value.
- R3: After each load only the 4-bit slot index increments, wrapping from 15 to 0 inside the same row. A later byte loaded into a slot replaces the earlier one.
- R4: A write cycle starts only when `stop_i` arrives while the last event since the previous load was that load. A `bit_i` or `addr_set_i` in between cancels this. A stop under any other condition discards the loaded bytes and leaves `busy_o` low.
- R5: `busy_o` rises in the cycle after an accepted stop and stays high for exactly `BUSY_CYCLES` cycles.
- R6: `rd_data_o` shows the committed byte at `rd_addr_i` in the same cycle. Bytes that are loaded but not yet committed never appear on it, even during `busy_o`. The array changes on the edge where `busy_o` falls.
- R7: While `busy_o` is high, `addr_set_i`, `load_i`, `bit_i` and `stop_i` have no effect.
- R8: The valid mask is empty after a commit, so a later stop with no new loads starts no write cycle.
- R9: A stop after an address but with no loaded data byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_set_i | input | 1 | Load start address strobe |
| addr_i | input | 8 | Start address |
| load_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| bit_i | input | 1 | Bus clocked a further bit |
| stop_i | input | 1 | Stop condition seen |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Committed byte at read address |
| busy_o | output | 1 | Write cycle in progress |

## Verification
Strobes are sampled on a rising edge. Their effect on the latch shows one cycle later, and `busy_o` also rises one cycle after an accepted stop. The array update and the fall of `busy_o` come `BUSY_CYCLES` edges after that stop. `rd_data_o` follows `rd_addr_i` with no register. The bench therefore drives inputs on the falling edge and compares 1 ns later, before the next rising edge. Its reference model advances by exactly one rising edge per step. Each compare in a step therefore reflects every edge up to that point, and none after.

// File: rtl/row_commit_pkg.sv
package row_commit_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/row_latch.sv
module row_latch #(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int ROW_BYTES = 1 << COL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        busy_i,
  input  logic                        clr_i,
  input  logic                        addr_set_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        load_i,
  input  logic [DATA_W-1:0]           data_i,
  input  logic                        bit_i,
  input  logic                        stop_i,
  output logic [ROW_W-1:0]            row_o,
  output logic [ROW_BYTES-1:0]        mask_o,
  output logic [ROW_BYTES*DATA_W-1:0] bytes_o,
  output logic                        armed_o
);
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     ptr_q;
  logic [ROW_BYTES-1:0] mask_q;
  logic                 armed_q;
  logic [DATA_W-1:0]    bytes_q [ROW_BYTES];

  logic acc_set, acc_load, acc_stop, acc_cancel;
  assign acc_set    = addr_set_i && !busy_i;
  assign acc_load   = load_i && !addr_set_i && !busy_i;
  assign acc_stop   = stop_i && !busy_i;
  assign acc_cancel = (bit_i || stop_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else if (acc_set) begin
      row_q   <= addr_i[ADDR_W-1:COL_W];
      ptr_q   <= addr_i[COL_W-1:0];
      armed_q <= 1'b0;
    end else if (acc_load) begin
      ptr_q   <= ptr_q + 1'b1;
      armed_q <= !(bit_i || stop_i);
    end else if (acc_cancel) begin
      armed_q <= 1'b0;
    end
  end

  // mask: cleared by new address, by a discarding stop, or after commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (clr_i || acc_set) begin
      mask_q <= '0;
    end else if (acc_stop && !(armed_q && |mask_q)) begin
      mask_q <= '0;
    end else if (acc_load) begin
      mask_q[ptr_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_q[g] <= '0;
      end else if (acc_load && ptr_q == COL_W'(g)) begin
        bytes_q[g] <= data_i;
      end
    end
    assign bytes_o[g*DATA_W +: DATA_W] = bytes_q[g];
  end

  assign row_o   = row_q;
  assign mask_o  = mask_q;
  assign armed_o = armed_q;

  a_r3_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !addr_set_i && !busy_i) |=> ptr_q == $past(ptr_q) + 1'b1 && $stable(row_q));

  a_r7_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(mask_q) && $stable(ptr_q) && $stable(row_q));

  a_r8_mask_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mask_q == '0);

  a_r2_set_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_set_i && !busy_i) |=> mask_q == '0 && !armed_q);
endmodule

// File: rtl/commit_seq.sv
module commit_seq
  import row_commit_pkg::*;
#(
  parameter int BUSY_CYCLES = 2_000_000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic armed_i,
  input  logic mask_any_i,
  output logic busy_o,
  output logic done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go;

  assign go     = (state_q == SEQ_IDLE) && stop_i && armed_i && mask_any_i;
  assign done_o = (state_q == SEQ_BUSY) && (cnt_q == '0);
  assign busy_o = (state_q == SEQ_BUSY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go) begin
          state_q <= SEQ_BUSY;
          cnt_q   <= CNT_W'(BUSY_CYCLES - 1);
        end
        SEQ_BUSY: begin
          if (cnt_q == '0) state_q <= SEQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  a_r5_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy_o && cnt_q == CNT_W'(BUSY_CYCLES - 1));

  a_r5_busy_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r4_no_start_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(stop_i && armed_i)) |=> !busy_o);

  a_r9_no_start_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mask_any_i) |=> !busy_o);
endmodule

// File: rtl/nv_array.sv
module nv_array #(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT_BYTE = '1,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int ROW_BYTES = 1 << COL_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [ROW_BYTES-1:0]        mask_i,
  input  logic [ROW_BYTES*DATA_W-1:0] bytes_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    localparam int SLOT = g % ROW_BYTES;
    localparam int ROW  = g / ROW_BYTES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= INIT_BYTE;
      end else if (we_i && row_i == ROW_W'(ROW) && mask_i[SLOT]) begin
        mem_q[g] <= bytes_i[SLOT*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  a_r6_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));
endmodule

// File: rtl/row_commit_top.sv
module row_commit_top #(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int BUSY_CYCLES = 2_000_000,
  parameter logic [DATA_W-1:0] INIT_BYTE = '1,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int ROW_BYTES = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  logic [ROW_W-1:0]            row;
  logic [ROW_BYTES-1:0]        mask;
  logic [ROW_BYTES*DATA_W-1:0] bytes;
  logic                        armed, done, busy;

  row_latch #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni,
    .busy_i(busy), .clr_i(done),
    .addr_set_i, .addr_i, .load_i, .data_i, .bit_i, .stop_i,
    .row_o(row), .mask_o(mask), .bytes_o(bytes), .armed_o(armed)
  );

  commit_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i, .rst_ni, .stop_i,
    .armed_i(armed), .mask_any_i(|mask),
    .busy_o(busy), .done_o(done)
  );

  nv_array #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
             .INIT_BYTE(INIT_BYTE)) u_array (
    .clk_i, .rst_ni,
    .we_i(done), .row_i(row), .mask_i(mask), .bytes_i(bytes),
    .rd_addr_i, .rd_data_o
  );

  assign busy_o = busy;

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
endmodule

// File: tb/row_commit_top_tb.sv
`timescale 1ns/1ps
module row_commit_top_tb;
  localparam int BUSY = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic addr_set_i = 0, load_i = 0, bit_i = 0, stop_i = 0;
  logic [7:0] addr_i = 0, data_i = 0, rd_addr_i = 0;
  logic [7:0] rd_data_o;
  logic busy_o;

  always #2.5 clk = ~clk;

  row_commit_top #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni, .addr_set_i, .addr_i, .load_i, .data_i,
    .bit_i, .stop_i, .rd_addr_i, .rd_data_o, .busy_o
  );

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  logic [7:0] rd_sel = 0;

  // reference model
  logic [7:0] mem_m [256];
  logic [7:0] lat_m [16];
  bit         msk_m [16];
  int ptr_m = 0, row_m = 0, cnt_m = 0;
  bit armed_m = 0, busy_m = 0;

  function automatic bit any_mask();
    for (int i = 0; i < 16; i++) if (msk_m[i]) return 1;
    return 0;
  endfunction

  task automatic clear_mask();
    for (int i = 0; i < 16; i++) msk_m[i] = 0;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(bit as, logic [7:0] a, bit ld, logic [7:0] d, bit bt, bit sp);
    @(negedge clk);
    addr_set_i = as; addr_i = a; load_i = ld; data_i = d; bit_i = bt; stop_i = sp;
    rd_addr_i = rd_sel;
    #1;
    chk({cur_req, " rd_data"}, rd_data_o, mem_m[rd_sel]);
    chk({cur_req, " busy"}, {7'd0, busy_o}, {7'd0, busy_m});
    rd_sel = rd_sel + 8'd37;
    if (busy_m) begin
      cnt_m--;
      if (cnt_m == 0) begin
        for (int i = 0; i < 16; i++) if (msk_m[i]) mem_m[row_m*16+i] = lat_m[i];
        clear_mask();
        busy_m = 0;
      end
    end else begin
      if (as) begin
        row_m = a / 16; ptr_m = a % 16; clear_mask(); armed_m = 0;
      end else if (ld) begin
        lat_m[ptr_m] = d; msk_m[ptr_m] = 1; ptr_m = (ptr_m + 1) % 16; armed_m = 1;
      end
      if (bt) armed_m = 0;
      if (sp) begin
        if (armed_m && any_mask()) begin busy_m = 1; cnt_m = BUSY; end
        else clear_mask();
        armed_m = 0;
      end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
  task automatic peek(logic [7:0] a, logic [7:0] exp, string req);
    rd_sel = a; idle();
    chk(req, rd_data_o, exp);
  endtask
  task automatic wait_done();
    for (int i = 0; i < 4*BUSY && busy_m; i++) idle();
    idle();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    clear_mask();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset contents, sweep all addresses
    cur_req = "R1";
    for (int i = 0; i < 256; i++) peek(i[7:0], 8'hFF, "R1");

    // R2, R5, R6: three bytes at 0x35, reads during busy see old data
    cur_req = "R2";
    step(1, 8'h35, 0, 0, 0, 0);
    step(0, 0, 1, 8'hA1, 0, 0);
    step(0, 0, 1, 8'hB2, 0, 0);
    step(0, 0, 1, 8'hC3, 0, 0);
    cur_req = "R5";
    step(0, 0, 0, 0, 0, 1);
    cur_req = "R6";
    peek(8'h36, 8'hFF, "R6 read during busy");
    // R7: strobes during busy
    cur_req = "R7";
    step(1, 8'h90, 0, 0, 0, 0);
    step(0, 0, 1, 8'h5A, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    wait_done();
    cur_req = "R2";
    peek(8'h35, 8'hA1, "R2");
    peek(8'h36, 8'hB2, "R2");
    peek(8'h37, 8'hC3, "R2");
    peek(8'h34, 8'hFF, "R2 neighbour");
    peek(8'h38, 8'hFF, "R2 neighbour");
    peek(8'h90, 8'hFF, "R7 ignored address");
    // R8: stop again with no loads
    cur_req = "R8";
    step(0, 0, 0, 0, 0, 1);
    idle(); idle();

    // R3: 18 bytes from 0x7E wrap in row
    cur_req = "R3";
    step(1, 8'h7E, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) step(0, 0, 1, 8'h10 + i[7:0], 0, 0);
    step(0, 0, 0, 0, 0, 1);
    wait_done();
    peek(8'h7E, 8'h20, "R3 overwrite");
    peek(8'h7F, 8'h21, "R3 overwrite");
    peek(8'h70, 8'h12, "R3 wrap");
    peek(8'h7D, 8'h1F, "R3 wrap");
    peek(8'h80, 8'hFF, "R3 row edge");
    peek(8'h6F, 8'hFF, "R3 row edge");

    // R4: bit between load and stop discards
    cur_req = "R4";
    step(1, 8'hC0, 0, 0, 0, 0);
    step(0, 0, 1, 8'h77, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    idle();
    step(0, 0, 0, 0, 0, 1);
    idle();
    peek(8'hC0, 8'hFF, "R4 discarded");

    // R2: new address drops earlier bytes
    cur_req = "R2";
    step(1, 8'h10, 0, 0, 0, 0);
    step(0, 0, 1, 8'h44, 0, 0);
    step(0, 0, 1, 8'h45, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    step(0, 0, 1, 8'h66, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    wait_done();
    peek(8'h22, 8'h66, "R2 after re-address");
    peek(8'h10, 8'hFF, "R2 dropped");
    peek(8'h21, 8'hFF, "R2 dropped");

    // R9: address then stop, no data
    cur_req = "R9";
    step(1, 8'hE4, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(); idle();

    // final sweep
    cur_req = "R6";
    for (int i = 0; i < 256; i++) begin rd_sel = i[7:0]; idle(); end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule